// File: doc/BRIEF.md
# Two-Port Parallel I/O with Banked Data/Direction Access

This block is a small parallel I/O peripheral with two 8-bit ports, A and B, on a simple processor bus. The bus has a chip select, a write strobe (high means write, low means read), a 2-bit register select and an 8-bit data path in each direction. Each port owns three registers: an output latch, a direction register and a control register. The bus decodes only four addresses, so the output latch and the direction register of a port share one address. Bit 2 of that port's control register picks which of the two the shared address reaches.

Pins are brought out as three separate vectors per port: incoming pin values, outgoing drive values and per-bit output enables. A direction bit of 1 enables the driver, and a 0 leaves the pin as an input. Software can treat a line as open-drain by writing 0 to its output latch and then toggling only its direction bit. Incoming pins pass through a two-stage synchronizer before software can read them.

Top module: `pio_bank_port`

## Requirements
- R1: After reset every direction, output-latch and control register is zero. All output enables and drive values are 0, and reads at offsets 0, 1, 2 and 3 all return 0x00.
- R2: Offset 1 is port A's control register and offset 3 is port B's. All 8 bits written there read back unchanged.
- R3: When bit 2 of port A's control register is 0, a write to offset 0 loads port A's direction register, which drives `pin_oe_a`. A read of offset 0 returns that register. The output latch is left unchanged.
- R4: When bit 2 of port A's control register is 1, a write to offset 0 loads port A's output latch, which drives `pin_out_a`. The direction register is left unchanged.
- R5: Offset 2 and port B's control register bit 2 behave for port B the same way R3 and R4 describe for port A. Accesses to one port never alter the other port's registers.
- R6: A data-path read (bank bit 1) returns, for each bit, the output-latch value if that bit's direction is 1 and the synchronized pin value if it is 0.
- R7: A change on an input pin applied between clock edges shows in a data-path read after exactly two rising edges, and not after one.
- R8: Registers change only on a rising edge with both `cs` and `we` high. A write strobe while `cs` is low changes nothing. `rdata` is 0x00 whenever the bus is not performing a read.
- R9: With the output latch bits at 0, rewriting only the direction register switches `pin_oe` while `pin_out` stays 0 (open-drain use).
- R10: Control bits other than bit 2 have no effect on which register offsets 0 and 2 reach, or on any pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | 1 = write, 0 = read (qualified by cs) |
| rs | input | 2 | Register select (offset 0..3) |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational, 0 when not reading |
| pin_in_a | input | DW | Port A pin levels from the pads |
| pin_out_a | output | DW | Port A drive values |
| pin_oe_a | output | DW | Port A output enables |
| pin_in_b | input | DW | Port B pin levels from the pads |
| pin_out_b | output | DW | Port B drive values |
| pin_oe_b | output | DW | Port B output enables |

## Verification
Two things can happen in the same clock cycle: a pad edge entering the synchronizer and a bus write to the direction register that turns the same bits into outputs. The bench provokes this by changing `pin_in_a` on the same falling edge that starts the direction write. It then moves the bank bit to the data path and reads. The read must return the latched output bits and not the new pad value. A separate sequence judges the synchronizer delay alone, with reads one and two rising edges after a pad change.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  localparam int unsigned PIO_NPORT    = 2;
  localparam int unsigned PIO_RS_W     = 2;
  localparam int unsigned PIO_NREG     = 1 << PIO_RS_W;
  localparam int unsigned PIO_BANK_BIT = 2;
endpackage

// File: rtl/pio_sync.sv
`timescale 1ns/1ps
module pio_sync #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d_async,
  output logic [DW-1:0] d_sync
);
  logic [DW-1:0] meta_q;
  logic [DW-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign d_sync = stab_q;
endmodule

// File: rtl/pio_port_slice.sv
`timescale 1ns/1ps
module pio_port_slice #(
  parameter int unsigned DW       = 8,
  parameter int unsigned BANK_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_shared,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_sync,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] ddr_q,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] shared_rd
);
  logic          bank_data;
  logic          out_en, ddr_en, ctl_en;
  logic [DW-1:0] out_d, ddr_d, ctl_d;
  logic [DW-1:0] data_view;

  assign bank_data = ctl_q[BANK_BIT];

  // next-state and clock enables
  always_comb begin
    out_en = wr_shared &  bank_data;
    ddr_en = wr_shared & ~bank_data;
    ctl_en = wr_ctl;
    out_d  = wdata;
    ddr_d  = wdata;
    ctl_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      ddr_q <= '0;
      ctl_q <= '0;
    end else begin
      if (out_en) out_q <= out_d;
      if (ddr_en) ddr_q <= ddr_d;
      if (ctl_en) ctl_q <= ctl_d;
    end
  end

  // per-bit mix: driven bits report the latch, input bits report the pad
  always_comb begin
    data_view = (out_q & ddr_q) | (pin_sync & ~ddr_q);
    shared_rd = bank_data ? data_view : ddr_q;
  end
endmodule

// File: rtl/pio_bank_port.sv
`timescale 1ns/1ps
module pio_bank_port
  import pio_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                we,
  input  logic [PIO_RS_W-1:0] rs,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  input  logic [DW-1:0]       pin_in_a,
  output logic [DW-1:0]       pin_out_a,
  output logic [DW-1:0]       pin_oe_a,
  input  logic [DW-1:0]       pin_in_b,
  output logic [DW-1:0]       pin_out_b,
  output logic [DW-1:0]       pin_oe_b
);
  localparam int unsigned NPORT = PIO_NPORT;
  localparam int unsigned NREG  = PIO_NREG;

  logic          wr_en, rd_en;
  logic [DW-1:0] pin_in_v  [NPORT];
  logic [DW-1:0] pin_syn_v [NPORT];
  logic [DW-1:0] out_q     [NPORT];
  logic [DW-1:0] ddr_q     [NPORT];
  logic [DW-1:0] ctl_q     [NPORT];
  logic [DW-1:0] rd_word   [NREG];

  assign wr_en = cs &  we;
  assign rd_en = cs & ~we;

  assign pin_in_v[0] = pin_in_a;
  assign pin_in_v[1] = pin_in_b;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam logic [PIO_RS_W-1:0] OFF_SH  = PIO_RS_W'(2 * g);
    localparam logic [PIO_RS_W-1:0] OFF_CTL = PIO_RS_W'(2 * g + 1);

    logic wr_sh, wr_ct;
    assign wr_sh = wr_en && (rs == OFF_SH);
    assign wr_ct = wr_en && (rs == OFF_CTL);

    pio_sync #(.DW(DW)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in_v[g]),
      .d_sync  (pin_syn_v[g])
    );

    pio_port_slice #(.DW(DW), .BANK_BIT(PIO_BANK_BIT)) i_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_shared (wr_sh),
      .wr_ctl    (wr_ct),
      .wdata     (wdata),
      .pin_sync  (pin_syn_v[g]),
      .out_q     (out_q[g]),
      .ddr_q     (ddr_q[g]),
      .ctl_q     (ctl_q[g]),
      .shared_rd (rd_word[2*g])
    );

    assign rd_word[2*g+1] = ctl_q[g];
  end

  assign rdata = rd_en ? rd_word[rs] : '0;

  assign pin_out_a = out_q[0];
  assign pin_oe_a  = ddr_q[0];
  assign pin_out_b = out_q[1];
  assign pin_oe_b  = ddr_q[1];
endmodule

// File: rtl/pio_bank_port_chk.sv
`timescale 1ns/1ps
module pio_bank_port_chk #(
  parameter int unsigned DW       = 8,
  parameter int unsigned BANK_BIT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          we,
  input logic [1:0]    rs,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pin_out_a,
  input logic [DW-1:0] pin_oe_a,
  input logic [DW-1:0] pin_out_b,
  input logic [DW-1:0] pin_oe_b,
  input logic [DW-1:0] ctl_a,
  input logic [DW-1:0] ctl_b
);
  a_r2_ctl_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && rs == 2'd1) |=> (ctl_a == $past(wdata)));

  a_r3_dir_write_a: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && rs == 2'd0 && !ctl_a[BANK_BIT]) |=>
      (pin_oe_a == $past(wdata)) && $stable(pin_out_a));

  a_r4_data_write_a: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && rs == 2'd0 && ctl_a[BANK_BIT]) |=>
      (pin_out_a == $past(wdata)) && $stable(pin_oe_a));

  a_r5_dir_write_b: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && rs == 2'd2 && !ctl_b[BANK_BIT]) |=>
      (pin_oe_b == $past(wdata)) && $stable(pin_out_b) &&
      $stable(pin_out_a) && $stable(pin_oe_a));

  a_r5_data_write_b: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && rs == 2'd2 && ctl_b[BANK_BIT]) |=>
      (pin_out_b == $past(wdata)) && $stable(pin_oe_b) &&
      $stable(pin_out_a) && $stable(pin_oe_a));

  a_r8_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && we) |=> $stable(pin_out_a) && $stable(pin_oe_a) &&
                    $stable(pin_out_b) && $stable(pin_oe_b));

  a_r8_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !we) |-> (rdata == '0));
endmodule

bind pio_bank_port pio_bank_port_chk #(.DW(DW), .BANK_BIT(pio_pkg::PIO_BANK_BIT)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .we        (we),
  .rs        (rs),
  .wdata     (wdata),
  .rdata     (rdata),
  .pin_out_a (pin_out_a),
  .pin_oe_a  (pin_oe_a),
  .pin_out_b (pin_out_b),
  .pin_oe_b  (pin_oe_b),
  .ctl_a     (ctl_q[0]),
  .ctl_b     (ctl_q[1])
);

// File: tb/test_pio_bank_port.sv
`timescale 1ns/1ps
module test_pio_bank_port;
  localparam int DW = 8;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs, we;
  logic [1:0]    rs;
  logic [DW-1:0] wdata, rdata;
  logic [DW-1:0] pin_in_a, pin_out_a, pin_oe_a;
  logic [DW-1:0] pin_in_b, pin_out_b, pin_oe_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  rd_item_t exp_q[$];

  always #2 clk = ~clk;

  pio_bank_port #(.DW(DW)) i_pio_bank_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .rs(rs),
    .wdata(wdata), .rdata(rdata),
    .pin_in_a(pin_in_a), .pin_out_a(pin_out_a), .pin_oe_a(pin_oe_a),
    .pin_in_b(pin_in_b), .pin_out_b(pin_out_b), .pin_oe_b(pin_oe_b)
  );

  // monitor: compares read data with the scoreboard, away from the edge
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      n_tests++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata actual %02h expected %02h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; rs = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    cs = 1'b1; we = 1'b0; rs = a;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] e, input string tag);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, e);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; rs = 2'd0; wdata = '0;
    pin_in_a = 8'h00; pin_in_b = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(2'd0, 8'h00, "R1 offset0");
    rd(2'd1, 8'h00, "R1 offset1");
    rd(2'd2, 8'h00, "R1 offset2");
    rd(2'd3, 8'h00, "R1 offset3");
    idle();
    chk(pin_oe_a,  8'h00, "R1 oe_a");
    chk(pin_oe_b,  8'h00, "R1 oe_b");
    chk(pin_out_a, 8'h00, "R1 out_a");
    chk(pin_out_b, 8'h00, "R1 out_b");

    // R2 / R3: control readback, direction bank on port A
    wr(2'd1, 8'hA1);
    rd(2'd1, 8'hA1, "R2 ctl_a readback");
    wr(2'd0, 8'h0F);
    idle();
    chk(pin_oe_a,  8'h0F, "R3 oe_a from dir write");
    chk(pin_out_a, 8'h00, "R3 latch untouched");
    rd(2'd0, 8'h0F, "R3 dir readback");

    // R4 / R6 / R7: data bank on port A
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h5A);
    idle();
    chk(pin_out_a, 8'h5A, "R4 out_a from data write");
    chk(pin_oe_a,  8'h0F, "R4 dir untouched");
    @(negedge clk); pin_in_a = 8'hC3;
    rd(2'd0, 8'h0A, "R7 one edge: old pad value");
    rd(2'd0, 8'hCA, "R7/R6 two edges: mixed read");

    // R8: strobe without chip select, rdata idle
    @(negedge clk);
    cs = 1'b0; we = 1'b1; rs = 2'd0; wdata = 8'hFF;
    #1;
    chk(rdata, 8'h00, "R8 rdata idle during write strobe");
    idle();
    chk(pin_out_a, 8'h5A, "R8 write without cs ignored");
    chk(rdata,     8'h00, "R8 rdata idle");

    // R5 / R10: port B, other control bits set
    wr(2'd3, 8'hFB);
    rd(2'd3, 8'hFB, "R2 ctl_b readback");
    wr(2'd2, 8'hF0);
    idle();
    chk(pin_oe_b,  8'hF0, "R10/R5 offset2 still reaches dir");
    chk(pin_out_b, 8'h00, "R10 no pin effect of ctl bits");
    chk(pin_out_a, 8'h5A, "R5 port A out isolated");
    chk(pin_oe_a,  8'h0F, "R5 port A dir isolated");
    rd(2'd2, 8'hF0, "R5 dir_b readback");
    wr(2'd3, 8'h04);
    rd(2'd2, 8'h0C, "R5/R6 port B data read");

    // R9: open-drain toggling on port B
    wr(2'd3, 8'h00);
    wr(2'd2, 8'hF1);
    idle();
    chk(pin_oe_b,  8'hF1, "R9 oe asserted");
    chk(pin_out_b, 8'h00, "R9 drive stays low");
    wr(2'd2, 8'hF0);
    idle();
    chk(pin_oe_b,  8'hF0, "R9 oe released");
    chk(pin_out_b, 8'h00, "R9 drive still low");

    // same-cycle: pad edge and direction write together (R6)
    wr(2'd1, 8'h00);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; rs = 2'd0; wdata = 8'hFF; pin_in_a = 8'h00;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    wr(2'd1, 8'h04);
    rd(2'd0, 8'h5A, "R6 all outputs read latch");
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule